// File: doc/BRIEF.md
# Thermal Throttle Monitor with Hysteresis

This block decides when a processor should be slowed down because the die is too hot. It reads a factory calibration word and a stream of temperature-sensor counts. It also accepts a throttle temperature set by software, given in deci-Celsius. From these it derives two count thresholds by linear interpolation between a room-temperature point and a hot point.

The sensor scale is inverted: a lower count means a hotter die. The trip threshold belongs to the throttle temperature. The release threshold belongs to a temperature 5 °C lower. The release threshold is therefore a larger count, and the space between the two thresholds forms a hysteresis band.

An internal periodic tick sets how often the block compares the latest accepted sample against the thresholds. At each check it drives a single slow/fast request. Threshold arithmetic uses a shared multi-cycle restoring divider: a calibration load or a new throttle temperature starts two divisions in sequence, one for the trip count and one for the release count. The trip count is also driven out as the sensor alarm value.

Top module: `thermal_throttle_mon`

## Requirements
- R1: The calibration word holds the room count in bits [31:20], the hot count in bits [19:8] and the hot temperature in whole °C in bits [7:0]. The hot temperature in deci-Celsius (hot_val) is that field multiplied by 10. The room point is fixed at 250 deci-Celsius.
- R2: The threshold for a temperature T is (room − hot) × (hot_val − T) / (hot_val − 250) + hot, using integer division that truncates. The result saturates at 4095. It equals the hot count when T ≥ hot_val, when room ≤ hot, or when hot_val ≤ 250.
- R3: Pulsing `cal_load` latches the calibration word and sets the throttle temperature to hot_val − 100, floored at 0. It then computes the trip count for that temperature and the release count for a temperature 50 lower, also floored at 0.
- R4: Pulsing `thr_wr` replaces the throttle temperature with `thr_temp` and recomputes both thresholds. `alarm_cnt` always equals `trip_cnt`.
- R5: `busy` is high from the cycle after a load or write request until both thresholds are updated. A new request during a computation restarts it, and only the last request's values are kept. If both requests arrive together, `cal_load` takes priority.
- R6: A sample is accepted only when `smp_stb` and `smp_ok` are both high. An accepted sample is shown on `last_cnt` from the next cycle. Any other sample leaves `last_cnt` unchanged.
- R7: No decision is made, and `slow_req` stays 0, until an accepted sample with a nonzero count has been seen.
- R8: At a check, the latest count compared with the thresholds decides the request:
  - below `trip_cnt`: `slow_req` is set to 1;
  - above `rls_cnt`: `slow_req` is cleared to 0;
  - otherwise, including a count equal to either threshold: `slow_req` is left unchanged.
- R9: A check occurs once every `TICK_CYCLES` clock cycles. A check that falls while `busy` is high is skipped.
- R10: After reset: `slow_req` = 0, `trip_cnt` = 0, `rls_cnt` = 4095, `last_cnt` = 0, `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cal_load | input | 1 | Pulse: latch calibration word and start threshold computation |
| cal_word | input | 32 | Calibration word (room count, hot count, hot °C) |
| thr_wr | input | 1 | Pulse: set a new throttle temperature |
| thr_temp | input | 16 | Throttle temperature in deci-Celsius |
| smp_stb | input | 1 | Sensor sample strobe |
| smp_ok | input | 1 | Sample valid bit |
| smp_cnt | input | 12 | Sensor count (lower means hotter) |
| busy | output | 1 | Threshold computation in progress |
| trip_cnt | output | 12 | Trip (go-slow) count threshold |
| rls_cnt | output | 12 | Release (go-fast) count threshold |
| alarm_cnt | output | 12 | Alarm value exported to the sensor, equal to the trip count |
| slow_req | output | 1 | 1 requests slow operation, 0 requests fast operation |
| last_cnt | output | 12 | Last accepted sensor count |

## Verification
A wrong divider or sequencer state appears on `trip_cnt` and `rls_cnt` as soon as `busy` falls, about fifty cycles after a request. A stale or corrupted sample register appears on `last_cnt` one cycle after the strobe. A wrong hysteresis state flips `slow_req` at the first check after a count lands inside the band or on a threshold, at most `TICK_CYCLES` cycles later. A broken first-sample guard shows as `slow_req` rising after a zero-count sample.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int CW          = 12;   // sensor count width
  localparam int TW          = 16;   // temperature width, deci-Celsius
  localparam int ROOM_DC     = 250;  // room calibration point
  localparam int TRIP_MARGIN = 100;  // default throttle below hot point
  localparam int RLS_MARGIN  = 50;   // release temperature below throttle
  localparam int NUMW        = 2 * CW;

  typedef struct packed {
    logic [CW-1:0] room;
    logic [CW-1:0] hot;
    logic [7:0]    hot_c;
  } cal_t;

  typedef enum logic [2:0] {
    C_IDLE, C_GO_TRIP, C_RUN_TRIP, C_GO_RLS, C_RUN_RLS
  } calc_st_t;
endpackage

// File: rtl/thm_div.sv
module thm_div #(
  parameter int NW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int SW = $clog2(NW + 1);

  logic [DW:0]   rem_q, rem_n;
  logic [NW-1:0] quo_q, quo_n;
  logic [DW-1:0] den_q;
  logic [SW-1:0] step_q, step_n;
  logic          run_q, run_n, done_n;
  logic [DW:0]   rem_sh;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q[DW-1:0], quo_q[NW-1]};
    ge     = rem_sh >= {1'b0, den_q};
    rem_n  = rem_q;
    quo_n  = quo_q;
    step_n = step_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start) begin
      rem_n  = '0;
      quo_n  = num;
      step_n = SW'(NW);
      run_n  = 1'b1;
    end else if (run_q) begin
      rem_n  = ge ? rem_sh - {1'b0, den_q} : rem_sh;
      quo_n  = {quo_q[NW-2:0], ge};
      step_n = step_q - 1'b1;
      if (step_q == SW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      step_q <= step_n;
      run_q  <= run_n;
      done   <= done_n;
      if (start) den_q <= den;
    end
  end

  assign quo = quo_q;

  // R2: a result is only announced at the end of a running division
  a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run_q));
endmodule

// File: rtl/thm_calc.sv
module thm_calc
  import thm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_load,
  input  logic [31:0]   cal_word,
  input  logic          thr_wr,
  input  logic [TW-1:0] thr_temp,
  output logic          busy,
  output logic [CW-1:0] trip_cnt,
  output logic [CW-1:0] rls_cnt
);
  calc_st_t      st_q, st_n;
  cal_t          cal_q, cal_n, cal_in;
  logic [TW-1:0] thr_q, thr_n, rls_t, cur_t;
  logic [CW-1:0] trip_q, trip_n, rls_q, rls_n;
  logic [CW-1:0] hot_val, new_hv, diff, span, den;
  logic [NUMW-1:0] num, quo;
  logic [NUMW:0]   sum;
  logic [CW-1:0]   res;
  logic            degen, div_start, div_done, req;

  assign cal_in  = cal_t'(cal_word);
  assign new_hv  = CW'({cal_in.hot_c, 3'b000}) + CW'({cal_in.hot_c, 1'b0});
  assign hot_val = CW'({cal_q.hot_c, 3'b000}) + CW'({cal_q.hot_c, 1'b0});
  assign rls_t   = (thr_q >= TW'(RLS_MARGIN)) ? thr_q - TW'(RLS_MARGIN) : '0;
  assign cur_t   = (st_q == C_GO_RLS || st_q == C_RUN_RLS) ? rls_t : thr_q;

  // interpolation operands
  assign degen = (cal_q.room <= cal_q.hot) || (hot_val <= CW'(ROOM_DC));
  assign diff  = cal_q.room - cal_q.hot;
  assign span  = (cur_t >= TW'(hot_val)) ? '0 : hot_val - cur_t[CW-1:0];
  assign num   = degen ? '0 : NUMW'(diff) * NUMW'(span);
  assign den   = degen ? CW'(1) : hot_val - CW'(ROOM_DC);
  assign sum   = {1'b0, quo} + (NUMW+1)'(cal_q.hot);
  assign res   = (sum > (NUMW+1)'({CW{1'b1}})) ? {CW{1'b1}} : sum[CW-1:0];

  assign div_start = (st_q == C_GO_TRIP) || (st_q == C_GO_RLS);
  assign req       = cal_load || thr_wr;

  thm_div #(.NW(NUMW), .DW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(num), .den(den), .done(div_done), .quo(quo)
  );

  always_comb begin
    st_n   = st_q;
    cal_n  = cal_q;
    thr_n  = thr_q;
    trip_n = trip_q;
    rls_n  = rls_q;
    if (cal_load) begin
      cal_n = cal_in;
      thr_n = (new_hv >= CW'(TRIP_MARGIN)) ? TW'(new_hv - CW'(TRIP_MARGIN)) : '0;
      st_n  = C_GO_TRIP;
    end else if (thr_wr) begin
      thr_n = thr_temp;
      st_n  = C_GO_TRIP;
    end else begin
      unique case (st_q)
        C_GO_TRIP:  st_n = C_RUN_TRIP;
        C_RUN_TRIP: if (div_done) begin trip_n = res; st_n = C_GO_RLS; end
        C_GO_RLS:   st_n = C_RUN_RLS;
        C_RUN_RLS:  if (div_done) begin rls_n = res; st_n = C_IDLE; end
        default:    st_n = C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      cal_q  <= '0;
      thr_q  <= '0;
      trip_q <= '0;
      rls_q  <= '1;
    end else begin
      st_q   <= st_n;
      cal_q  <= cal_n;
      thr_q  <= thr_n;
      trip_q <= trip_n;
      rls_q  <= rls_n;
    end
  end

  assign busy     = (st_q != C_IDLE);
  assign trip_cnt = trip_q;
  assign rls_cnt  = rls_q;

  // R5: every request opens a computation
  a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> busy);
  // R3: when settled, the release count never lies below the trip count
  a_r3_band_order: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> trip_q <= rls_q);
endmodule

// File: rtl/thm_decide.sv
module thm_decide
  import thm_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic          smp_ok,
  input  logic [CW-1:0] smp_cnt,
  input  logic          busy,
  input  logic [CW-1:0] trip_cnt,
  input  logic [CW-1:0] rls_cnt,
  output logic          slow_req,
  output logic [CW-1:0] last_cnt
);
  localparam int TKW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [TKW-1:0] tk_q, tk_n;
  logic [CW-1:0]  last_q, last_n;
  logic           seen_q, seen_n, slow_q, slow_n, tick, take;

  assign tick = (tk_q == TKW'(TICK_CYCLES - 1));
  assign take = smp_stb && smp_ok;

  always_comb begin
    tk_n   = tick ? '0 : tk_q + 1'b1;
    last_n = last_q;
    seen_n = seen_q;
    slow_n = slow_q;
    if (take) begin
      last_n = smp_cnt;
      if (smp_cnt != '0) seen_n = 1'b1;
    end
    if (tick && !busy && seen_q) begin
      if (last_q < trip_cnt)     slow_n = 1'b1;
      else if (last_q > rls_cnt) slow_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q   <= '0;
      last_q <= '0;
      seen_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      tk_q   <= tk_n;
      last_q <= last_n;
      seen_q <= seen_n;
      slow_q <= slow_n;
    end
  end

  assign slow_req = slow_q;
  assign last_cnt = last_q;

  // R6: the held count moves only on an accepted sample
  a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(last_q));
  // R7: no request before a nonzero count has been seen
  a_r7_need_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_q) |-> $past(seen_q));
  // R8: going slow only from a count under the trip threshold
  a_r8_slow_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_q) |-> $past(last_q < trip_cnt));
  // R8: going fast only from a count over the release threshold
  a_r8_fast_cool: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_q) |-> $past(last_q > rls_cnt));
endmodule

// File: rtl/thermal_throttle_mon.sv
module thermal_throttle_mon
  import thm_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_load,
  input  logic [31:0]   cal_word,
  input  logic          thr_wr,
  input  logic [15:0]   thr_temp,
  input  logic          smp_stb,
  input  logic          smp_ok,
  input  logic [11:0]   smp_cnt,
  output logic          busy,
  output logic [11:0]   trip_cnt,
  output logic [11:0]   rls_cnt,
  output logic [11:0]   alarm_cnt,
  output logic          slow_req,
  output logic [11:0]   last_cnt
);
  logic          busy_w;
  logic [CW-1:0] trip_w, rls_w;

  thm_calc u_calc (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_word(cal_word),
    .thr_wr(thr_wr), .thr_temp(thr_temp),
    .busy(busy_w), .trip_cnt(trip_w), .rls_cnt(rls_w)
  );

  thm_decide #(.TICK_CYCLES(TICK_CYCLES)) u_decide (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_ok(smp_ok),
    .smp_cnt(smp_cnt), .busy(busy_w), .trip_cnt(trip_w), .rls_cnt(rls_w),
    .slow_req(slow_req), .last_cnt(last_cnt)
  );

  assign busy      = busy_w;
  assign trip_cnt  = trip_w;
  assign rls_cnt   = rls_w;
  assign alarm_cnt = trip_w;

  // R4: the exported alarm tracks the trip threshold
  a_r4_alarm_trip: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_cnt == trip_cnt);
endmodule

// File: tb/thermal_throttle_mon_test.sv
module thermal_throttle_mon_test;
  localparam int TICK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_load = 1'b0, thr_wr = 1'b0, smp_stb = 1'b0, smp_ok = 1'b0;
  logic [31:0] cal_word = '0;
  logic [15:0] thr_temp = '0;
  logic [11:0] smp_cnt = '0;
  logic        busy, slow_req;
  logic [11:0] trip_cnt, rls_cnt, alarm_cnt, last_cnt;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int c_room, c_hot, c_hv;

  always #5 clk = ~clk;

  thermal_throttle_mon #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_word(cal_word),
    .thr_wr(thr_wr), .thr_temp(thr_temp), .smp_stb(smp_stb), .smp_ok(smp_ok),
    .smp_cnt(smp_cnt), .busy(busy), .trip_cnt(trip_cnt), .rls_cnt(rls_cnt),
    .alarm_cnt(alarm_cnt), .slow_req(slow_req), .last_cnt(last_cnt)
  );

  // {count, expected slow_req} after each check; trip 1020, release 1050
  localparam logic [12:0] VEC [10] = '{
    {12'd1100, 1'b0}, {12'd1000, 1'b1}, {12'd1030, 1'b1}, {12'd1049, 1'b1},
    {12'd1050, 1'b1}, {12'd1051, 1'b0}, {12'd1020, 1'b0}, {12'd1019, 1'b1},
    {12'd1035, 1'b1}, {12'd2000, 1'b0}
  };

  function automatic int ref_cnt(int t);
    int v;
    if (c_room <= c_hot || c_hv <= 250 || t >= c_hv) return c_hot;
    v = (c_room - c_hot) * (c_hv - t) / (c_hv - 250) + c_hot;
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic load_cal(int room, int hot, int hc);
    c_room = room; c_hot = hot; c_hv = hc * 10;
    cal_word = {room[11:0], hot[11:0], hc[7:0]};
    cal_load = 1'b1; @(negedge clk); cal_load = 1'b0;
  endtask

  task automatic write_thr(int t);
    thr_temp = t[15:0]; thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic sample(bit ok, int c);
    smp_ok = ok; smp_cnt = c[11:0]; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0; smp_ok = 1'b0;
  endtask

  task automatic thr_check(string req, int t);
    chk(req, trip_cnt, ref_cnt(t));
    chk(req, rls_cnt, ref_cnt((t >= 50) ? t - 50 : 0));
    chk("R4 alarm", alarm_cnt, trip_cnt);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 slow", slow_req, 0);
    chk("R10 trip", trip_cnt, 0);
    chk("R10 rls", rls_cnt, 4095);
    chk("R10 last", last_cnt, 0);
    chk("R10 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: calibration sets default throttle at hot_val-100
    load_cal(1440, 960, 105);
    chk("R5 busy after load", busy, 1);
    wait_idle();
    thr_check("R1 R2 R3 default", c_hv - 100);
    chk("R3 trip value", trip_cnt, 1020);
    chk("R3 rls value", rls_cnt, 1050);

    // R7: nothing before the first nonzero sample
    repeat (TICK + 3) @(negedge clk);
    chk("R7 no sample", slow_req, 0);
    // R6: invalid sample ignored
    sample(0, 10);
    chk("R6 invalid ignored", last_cnt, 0);
    repeat (TICK + 3) @(negedge clk);
    chk("R6 no decision", slow_req, 0);
    // R7: zero count accepted but arms nothing
    sample(1, 0);
    repeat (TICK + 3) @(negedge clk);
    chk("R7 zero count", slow_req, 0);

    // R8 hysteresis table
    foreach (VEC[i]) begin
      sample(1, VEC[i][12:1]);
      chk("R6 last", last_cnt, VEC[i][12:1]);
      repeat (TICK + 3) @(negedge clk);
      chk($sformatf("R8 vec%0d", i), slow_req, VEC[i][0]);
    end

    // R9: a decision follows within one tick period
    sample(1, 100);
    lat = 0;
    while (!slow_req && lat < 3 * TICK) begin @(negedge clk); lat++; end
    chk("R9 latency bound", (lat <= TICK + 1) ? 1 : 0, 1);
    sample(1, 2000);
    repeat (TICK + 3) @(negedge clk);
    chk("R8 back fast", slow_req, 0);

    // R4: new throttle temperatures
    write_thr(1050); wait_idle();
    thr_check("R4 at hot", 1050);
    chk("R2 at hot trip", trip_cnt, 960);
    write_thr(200); wait_idle();
    thr_check("R2 below room", 200);

    // R5: restart mid-computation keeps the last request
    write_thr(600);
    repeat (5) @(negedge clk);
    chk("R5 busy mid", busy, 1);
    write_thr(1050); wait_idle();
    thr_check("R5 restart", 1050);

    // R2 corner cases
    load_cal(4095, 0, 26); wait_idle();
    thr_check("R2 saturate", c_hv - 100);
    chk("R2 sat value", trip_cnt, 4095);
    load_cal(1440, 960, 20); wait_idle();
    thr_check("R2 hot below room", 0);
    chk("R2 degenerate value", rls_cnt, 960);
    load_cal(100, 500, 105); wait_idle();
    chk("R2 inverted cal", trip_cnt, 500);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule